// File: doc/BRIEF.md
# Single-Wire Pulse-Count Rail Programmer

This block decodes one combined enable/programming pin into an enable, a 6-bit code for the negative rail and a one-cycle strobe that marks each new code. The pin is sampled against the system clock. It first passes through a two-flop synchroniser and then through a stability filter that removes glitches. A filtered rising level while the block is disabled raises the enable with code 000000, which is the default rail setting. An initialization window follows. Edges that arrive during that window are discarded.

After the initialization window, each filtered rising edge adds one to a pending count. When the pin stays high for the store window after the last edge, the pending count becomes the output code, the strobe pulses and the pending count returns to zero. A later burst then replaces the code. If the pin stays low for the off window, the block disables and the code returns to default. All windows are given in microseconds and converted to clock cycles through a clock-frequency parameter. A parameter chooses the wide variant (41 steps) or the narrow variant (31 steps).

Top module: `neg_rail_prog`

## Requirements
- R1: After reset, `en_o`, `code_o` and `code_vld_o` are all 0.
- R2: When the filtered pin rises while the block is disabled, `en_o` goes to 1 and `code_o` stays 000000.
- R3: Rising edges that complete within INIT_US of enable are not counted, so a store that follows them does not change the code.
- R4: After initialization, a burst of N rising edges followed by a store gives `code_o` equal to the unsigned binary value of N, for N of 1 or more.
- R5: A store happens when the pin has been high for STORE_US since the last counted edge and the pending count is non-zero. `code_vld_o` is then high for exactly one cycle per store. A burst of zero edges gives no strobe.
- R6: The count saturates at the variant maximum: 41 (101001) when WIDE_RANGE=1 and 31 (011111) when WIDE_RANGE=0. It never wraps.
- R7: If the filtered pin stays low for OFF_US, `en_o` returns to 0 and `code_o` to 000000. The next enable starts from the default code.
- R8: A change on the pin that lasts fewer than FILT_CYC cycles after synchronisation is neither counted nor seen as a low level.
- R9: The count restarts from zero after each store, so a second burst replaces the code instead of adding to it.
- R10: Low times shorter than OFF_US between programming pulses leave `en_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw enable/programming pin, asynchronous |
| en_o | output | 1 | Rail enable |
| code_o | output | CODE_W | Latched rail code, 0 = default |
| code_vld_o | output | 1 | One-cycle strobe for each newly latched code |

## Verification
The hardest state to reach from the ports is a counted edge arriving while the initialization timer is still running. The stimulus has to place a full low-high pulse after the filtered enable and before the window ends, without holding the pin low long enough to shut the block down. The bench places that pulse a fixed number of cycles after enable, well inside the window. It then holds the pin high past the store window and checks that the code is unchanged. A sweep of burst lengths from 0 to beyond both maxima drives wide and narrow instances in parallel, with a full disable between bursts, so saturation, the default code and the zero-edge case all appear in every pass.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_INIT, ST_RUN} mode_e;

  function automatic int max_code(input bit wide);
    return wide ? 41 : 31;
  endfunction
endpackage

// File: rtl/pin_filter.sv
module pin_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      stab_q <= '0;
      pin_o  <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (s2_q == pin_o) begin
        stab_q <= '0;
      end else if (stab_q == CW'(FILT_CYC - 1)) begin
        stab_q <= '0;
        pin_o  <= s2_q;
      end else begin
        stab_q <= stab_q + 1'b1;
      end
    end
  end

  // filtered level only ever takes a value the synchroniser held
  assert_filt_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o != $past(pin_o)) |-> (pin_o == $past(s2_q)));
endmodule

// File: rtl/win_timer.sv
module win_timer #(
  parameter int LIMIT = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (run_i && !hit_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum #(
  parameter int CODE_W = 6,
  parameter int MAX    = 41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [CODE_W-1:0] cnt_o
);
  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != MAX_C) cnt_o <= cnt_o + 1'b1;
  end

  assert_sat_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX_C && inc_i && !clr_i) |=> (cnt_o == MAX_C));
  assert_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= MAX_C);
endmodule

// File: rtl/neg_rail_prog.sv
module neg_rail_prog
  import nrp_pkg::*;
#(
  parameter int CLK_MHZ    = 25,
  parameter int INIT_US    = 350,
  parameter int STORE_US   = 80,
  parameter int OFF_US     = 200,
  parameter int FILT_CYC   = 25,
  parameter int CODE_W     = 6,
  parameter bit WIDE_RANGE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  output logic              en_o,
  output logic [CODE_W-1:0] code_o,
  output logic              code_vld_o
);
  localparam int INIT_CYC  = INIT_US * CLK_MHZ;
  localparam int STORE_CYC = STORE_US * CLK_MHZ;
  localparam int OFF_CYC   = OFF_US * CLK_MHZ;
  localparam int MAX       = max_code(WIDE_RANGE);
  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX);

  mode_e             state_q;
  logic              pin_f, pin_q, rise;
  logic              init_hit, store_hit, off_hit, store_fire;
  logic [CODE_W-1:0] acc_cnt;

  pin_filter #(.FILT_CYC(FILT_CYC)) i_filt (
    .clk_i, .rst_ni, .pin_i, .pin_o(pin_f)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_f;
  end
  assign rise = pin_f && !pin_q;

  win_timer #(.LIMIT(INIT_CYC)) i_init_tmr (
    .clk_i, .rst_ni, .clr_i(state_q != ST_INIT), .run_i(state_q == ST_INIT), .hit_o(init_hit)
  );
  win_timer #(.LIMIT(STORE_CYC)) i_store_tmr (
    .clk_i, .rst_ni, .clr_i(!pin_f || rise || state_q != ST_RUN), .run_i(pin_f), .hit_o(store_hit)
  );
  win_timer #(.LIMIT(OFF_CYC)) i_off_tmr (
    .clk_i, .rst_ni, .clr_i(pin_f), .run_i(!pin_f), .hit_o(off_hit)
  );

  assign store_fire = (state_q == ST_RUN) && store_hit && (acc_cnt != '0);

  pulse_accum #(.CODE_W(CODE_W), .MAX(MAX)) i_acc (
    .clk_i, .rst_ni,
    .clr_i(state_q != ST_RUN || store_fire),
    .inc_i(state_q == ST_RUN && rise),
    .cnt_o(acc_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_OFF;
      code_o     <= '0;
      code_vld_o <= 1'b0;
    end else begin
      code_vld_o <= 1'b0;
      unique case (state_q)
        ST_OFF: begin
          code_o <= '0;
          if (rise) state_q <= ST_INIT;
        end
        ST_INIT: begin
          if (off_hit)       state_q <= ST_OFF;
          else if (init_hit) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (off_hit) begin
            state_q <= ST_OFF;
            code_o  <= '0;
          end else if (store_fire) begin
            code_o     <= acc_cnt;
            code_vld_o <= 1'b1;
          end
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assign en_o = (state_q != ST_OFF);

  assert_init_ignore_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INIT) |-> (acc_cnt == '0));
  assert_vld_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_vld_o |-> (code_o != '0 && en_o));
  assert_vld_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_vld_o |=> !code_vld_o);
  assert_code_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o <= MAX_C);
  assert_off_default_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> (code_o == '0));
  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_vld_o |-> (acc_cnt == '0));
endmodule

// File: tb/test_neg_rail_prog.sv
module test_neg_rail_prog;
  localparam int FILT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic       en_w, en_n, vld_w, vld_n;
  logic [5:0] code_w, code_n;
  int checks = 0, fails = 0;
  int nv_w = 0, nv_n = 0;
  bit done = 0;

  always #4 clk = ~clk;

  neg_rail_prog #(.CLK_MHZ(1), .INIT_US(40), .STORE_US(20), .OFF_US(30),
                  .FILT_CYC(FILT), .CODE_W(6), .WIDE_RANGE(1'b1)) i_neg_rail_prog (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .en_o(en_w), .code_o(code_w), .code_vld_o(vld_w));

  neg_rail_prog #(.CLK_MHZ(1), .INIT_US(40), .STORE_US(20), .OFF_US(30),
                  .FILT_CYC(FILT), .CODE_W(6), .WIDE_RANGE(1'b0)) i_neg_rail_prog_n (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .en_o(en_n), .code_o(code_n), .code_vld_o(vld_n));

  always @(posedge clk) begin
    if (vld_w) nv_w <= nv_w + 1;
    if (vld_n) nv_n <= nv_n + 1;
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin = 1'b0; wcyc(6);
      pin = 1'b1; wcyc(6);
    end
  endtask

  task automatic clr_vld();
    wcyc(1);
    nv_w = 0; nv_n = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wcyc(3);
    chk(en_w == 0 && code_w == 0 && vld_w == 0, "R1 reset wide", code_w, 0);
    chk(en_n == 0 && code_n == 0 && vld_n == 0, "R1 reset narrow", code_n, 0);
    rst_n = 1'b1;
    wcyc(5);

    // sweep of burst lengths, full disable between bursts
    for (int n = 0; n <= 45; n++) begin
      int ew, en;
      pin = 1'b0; wcyc(40);
      chk(en_w == 0 && code_w == 0, "R7 disabled wide", code_w, 0);
      chk(en_n == 0 && code_n == 0, "R7 disabled narrow", code_n, 0);
      pin = 1'b1; wcyc(30);
      chk(en_w == 1 && code_w == 0, "R2 enable default wide", en_w, 1);
      chk(en_n == 1 && code_n == 0, "R2 enable default narrow", en_n, 1);
      wcyc(30);
      clr_vld();
      pulses(n);
      chk(en_w == 1 && en_n == 1, "R10 short lows keep enable", en_w, 1);
      wcyc(40);
      ew = (n > 41) ? 41 : n;
      en = (n > 31) ? 31 : n;
      chk(code_w == 6'(ew), "R4 R6 code wide", code_w, ew);
      chk(code_n == 6'(en), "R4 R6 code narrow", code_n, en);
      chk(nv_w == ((n > 0) ? 1 : 0), "R5 strobe count wide", nv_w, (n > 0) ? 1 : 0);
      chk(nv_n == ((n > 0) ? 1 : 0), "R5 strobe count narrow", nv_n, (n > 0) ? 1 : 0);
    end

    // R3: a pulse inside the init window is dropped
    pin = 1'b0; wcyc(40);
    pin = 1'b1; wcyc(10);
    clr_vld();
    pulses(1);
    wcyc(70);
    chk(code_w == 0, "R3 init edge ignored", code_w, 0);
    chk(nv_w == 0, "R3 no strobe", nv_w, 0);
    pulses(3); wcyc(40);
    chk(code_w == 3, "R4 burst after init", code_w, 3);

    // R9: second burst replaces
    clr_vld();
    pulses(5); wcyc(40);
    chk(code_w == 5 && code_n == 5, "R9 second burst replaces", code_w, 5);
    chk(nv_w == 1, "R9 single strobe", nv_w, 1);

    // R8: short glitches neither count nor disable
    clr_vld();
    for (int g = 0; g < 4; g++) begin
      pin = 1'b0; wcyc(FILT - 1);
      pin = 1'b1; wcyc(8);
    end
    wcyc(40);
    chk(code_w == 5 && en_w == 1, "R8 glitch ignored", code_w, 5);
    chk(nv_w == 0, "R8 no strobe", nv_w, 0);

    // R7: shutdown then re-enable starts from default
    pin = 1'b0; wcyc(40);
    chk(en_w == 0 && code_w == 0, "R7 shutdown", code_w, 0);
    pin = 1'b1; wcyc(60);
    chk(en_w == 1 && code_w == 0, "R7 re-enable default", code_w, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule